// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block turns up to eight already-synchronised GPIO pin inputs into interrupt requests. Software sets it up through a small register window on an APB-style bus. For each pin it chooses whether the pin can raise an interrupt at all, whether the request is hidden, whether the pin is level- or edge-sensitive, and which polarity counts as active. Edge events are held in a per-pin latch until software acknowledges them through a write-one-to-clear register. Level requests track the pin directly.

The block drives one interrupt line per pin and a combined line that is the OR of all of them. Software can read the combined per-pin result back from a status register. A pin is reported only when it is enabled and not masked. A latched edge survives masking, so unmasking the pin brings the request back. An event that arrives while the pin is disabled is never recorded.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every configuration register reads 0, all edge latches are clear, and `irq_o` and `irq_any_o` are low.
- R2: The enable register is at byte offset 0x30, mask at 0x34, trigger kind at 0x38 (1 = edge, 0 = level) and polarity at 0x3C (1 = rising / active-high, 0 = falling / active-low). Bit i controls pin i. A write stores the low NPINS bits, and a read returns them with the upper bits zero.
- R3: Status reads at offset 0x40 as pending AND enable AND NOT mask. `irq_o` equals that vector at all times, and `irq_any_o` is its OR.
- R4: A level-sensitive pin is pending exactly while its input equals its polarity bit, in the same cycle the input changes, with no register stage.
- R5: An edge-sensitive pin latches on the clock edge where the input differs from its value one cycle earlier in the direction its polarity bit selects. The request appears after that clock edge.
- R6: A latched edge stays set until a write to offset 0x4C with a 1 in that pin's bit. Bits written as 0 leave their latches untouched.
- R7: An edge that occurs while the pin's enable bit is 0 is not latched, and enabling the pin afterwards raises nothing.
- R8: A mask bit of 1 hides the pin from `irq_o` and status without clearing its latch. Clearing the mask bit brings the request back.
- R9: A write to offset 0x4C has no effect on a level-sensitive pin that is still at its active level.
- R10: If an acknowledge write to offset 0x4C and a new qualifying edge hit the same pin on the same clock, the latch stays set.
- R11: Offset 0x4C reads as zero, and a write to the status offset 0x40 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid during a selected read |
| pin_i | input | NPINS | Synchronised pin levels |
| irq_o | output | NPINS | Per-pin interrupt requests |
| irq_any_o | output | 1 | OR of all per-pin requests |

## Verification
The assertions assume that `pin_i` is already synchronous to `clk` and changes only between clock edges. They also assume that bus accesses follow the two-phase select-then-enable order, with address and data held through the access phase. The bench drives every pin and bus signal on the falling clock edge and always completes a setup phase before the access phase, so these assumptions hold. Clocked properties are disabled while reset is asserted, so the bench holds reset for several cycles before any stimulus.

// File: rtl/gpio_irq_pkg.sv
// Package: register offsets and address decode shared by the GPIO
// interrupt controller. Assumes byte addresses of at most 16 bits.
package gpio_irq_pkg;

    localparam logic [15:0] OFS_ENABLE = 16'h0030;
    localparam logic [15:0] OFS_MASK   = 16'h0034;
    localparam logic [15:0] OFS_KIND   = 16'h0038;
    localparam logic [15:0] OFS_POLAR  = 16'h003C;
    localparam logic [15:0] OFS_STATUS = 16'h0040;
    localparam logic [15:0] OFS_CLEAR  = 16'h004C;

    typedef enum logic [2:0] {
        SLOT_NONE,
        SLOT_ENABLE,
        SLOT_MASK,
        SLOT_KIND,
        SLOT_POLAR,
        SLOT_STATUS,
        SLOT_CLEAR
    } slot_e;

    // Map a byte address onto a register slot.
    function automatic slot_e decode_slot(input logic [15:0] addr);
        slot_e s;
        case (addr)
            OFS_ENABLE: s = SLOT_ENABLE;
            OFS_MASK:   s = SLOT_MASK;
            OFS_KIND:   s = SLOT_KIND;
            OFS_POLAR:  s = SLOT_POLAR;
            OFS_STATUS: s = SLOT_STATUS;
            OFS_CLEAR:  s = SLOT_CLEAR;
            default:    s = SLOT_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
// Register file for the GPIO interrupt controller.
// Holds the enable, mask, trigger-kind and polarity vectors, turns a
// write to the acknowledge offset into a one-cycle clear pulse vector,
// and returns read data combinationally during a selected read.
// Assumes NPINS <= DATA_W and ADDR_W <= 16; a write commits on the
// clock edge that ends the access phase.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [NPINS-1:0]  status_i,
    output logic [DATA_W-1:0] prdata,
    output logic [NPINS-1:0]  en_o,
    output logic [NPINS-1:0]  mask_o,
    output logic [NPINS-1:0]  kind_o,
    output logic [NPINS-1:0]  polar_o,
    output logic [NPINS-1:0]  ack_o
);

    localparam int PAD_W = 16;

    slot_e             slot;
    logic              wr_go;
    logic [NPINS-1:0]  wval;
    logic [NPINS-1:0]  en_q;
    logic [NPINS-1:0]  mask_q;
    logic [NPINS-1:0]  kind_q;
    logic [NPINS-1:0]  polar_q;

    assign slot  = decode_slot(PAD_W'(paddr));
    assign wr_go = psel && penable && pwrite;
    assign wval  = pwdata[NPINS-1:0];

    if (DATA_W > NPINS) begin : g_spare_bits
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^pwdata[DATA_W-1:NPINS];
    end

    // Configuration registers: load on a write access to their slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            mask_q  <= '0;
            kind_q  <= '0;
            polar_q <= '0;
        end else if (wr_go) begin
            case (slot)
                SLOT_ENABLE: en_q    <= wval;
                SLOT_MASK:   mask_q  <= wval;
                SLOT_KIND:   kind_q  <= wval;
                SLOT_POLAR:  polar_q <= wval;
                default:     ;
            endcase
        end
    end

    // Acknowledge pulse: write data of an access to the clear slot.
    always_comb begin
        ack_o = '0;
        if (wr_go && slot == SLOT_CLEAR) ack_o = wval;
    end

    // Read mux: zero outside a selected read and for the clear slot.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (slot)
                SLOT_ENABLE: prdata[NPINS-1:0] = en_q;
                SLOT_MASK:   prdata[NPINS-1:0] = mask_q;
                SLOT_KIND:   prdata[NPINS-1:0] = kind_q;
                SLOT_POLAR:  prdata[NPINS-1:0] = polar_q;
                SLOT_STATUS: prdata[NPINS-1:0] = status_i;
                default:     prdata = '0;
            endcase
        end
    end

    assign en_o    = en_q;
    assign mask_o  = mask_q;
    assign kind_o  = kind_q;
    assign polar_o = polar_q;

    // R11: the status slot never changes configuration state.
    p_status_write_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && slot == SLOT_STATUS) |=> ($stable(en_q) && $stable(mask_q)
                                            && $stable(kind_q) && $stable(polar_q)));

    // R6: an acknowledge pulse only ever comes from a write access.
    p_ack_from_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o != '0) |-> (psel && penable && pwrite));

endmodule

// File: rtl/gpio_irq_pin.sv
// One pin's interrupt cell: edge detector, edge latch, level compare
// and enable/mask gating. Assumes pin_i is already synchronous to clk.
// The latch arms only while the pin is enabled and set to edge mode;
// a new edge outranks a simultaneous acknowledge.
module gpio_irq_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic en_i,
    input  logic mask_i,
    input  logic kind_i,
    input  logic polar_i,
    input  logic ack_i,
    output logic irq_o
);

    logic prev_q;
    logic latch_q;
    logic rise;
    logic fall;
    logic hit;
    logic arm;
    logic level_on;
    logic pend;

    assign rise     = pin_i & ~prev_q;
    assign fall     = ~pin_i & prev_q;
    assign hit      = polar_i ? rise : fall;
    assign arm      = hit & en_i & kind_i;
    assign level_on = ~(pin_i ^ polar_i);
    assign pend     = kind_i ? latch_q : level_on;
    assign irq_o    = pend & en_i & ~mask_i;

    // Previous-cycle sample of the pin for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_i;
    end

    // Edge latch: set on a qualifying edge, else clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)     latch_q <= 1'b0;
        else if (arm)   latch_q <= 1'b1;
        else if (ack_i) latch_q <= 1'b0;
    end

    // R7: the latch can only rise after an enabled edge-mode cycle.
    p_latch_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_q) |-> $past(en_i && kind_i));

    // R6: without an acknowledge a set latch holds.
    p_latch_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !ack_i) |=> latch_q);

    // R6: an acknowledge with no competing edge clears the latch.
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !arm) |=> !latch_q);

    // R10: a new edge on the acknowledge cycle keeps the latch set.
    p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && arm) |=> latch_q);

endmodule

// File: rtl/gpio_irq_ctrl.sv
// GPIO interrupt controller top: one register file plus one interrupt
// cell per pin, with a combined OR output. Assumes synchronised pins,
// NPINS <= DATA_W and a two-phase bus access.
module gpio_irq_ctrl #(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [NPINS-1:0]  pin_i,
    output logic [NPINS-1:0]  irq_o,
    output logic              irq_any_o
);

    logic [NPINS-1:0] en_w;
    logic [NPINS-1:0] mask_w;
    logic [NPINS-1:0] kind_w;
    logic [NPINS-1:0] polar_w;
    logic [NPINS-1:0] ack_w;
    logic [NPINS-1:0] irq_w;

    gpio_irq_regs #(
        .NPINS (NPINS),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .status_i(irq_w),
        .prdata  (prdata),
        .en_o    (en_w),
        .mask_o  (mask_w),
        .kind_o  (kind_w),
        .polar_o (polar_w),
        .ack_o   (ack_w)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_irq_pin u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[i]),
            .en_i   (en_w[i]),
            .mask_i (mask_w[i]),
            .kind_i (kind_w[i]),
            .polar_i(polar_w[i]),
            .ack_i  (ack_w[i]),
            .irq_o  (irq_w[i])
        );
    end

    assign irq_o     = irq_w;
    assign irq_any_o = |irq_w;

    // R3: no request leaves the block for a disabled or masked pin.
    p_irq_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_w & ~(en_w & ~mask_w)) == '0);

    // R1: the cycle after reset no request is active.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));

endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;

    localparam int NP = 8;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [DW-1:0] prdata;
    logic [NP-1:0] pins = '0;
    logic [NP-1:0] irq;
    logic          irq_any;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(NP), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pin_i(pins), .irq_o(irq), .irq_any_o(irq_any)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    logic [NP-1:0] m_en, m_msk, m_kind, m_pol, m_lat, m_prev;

    function automatic logic [NP-1:0] model_irq();
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++) begin
            logic p;
            p = m_kind[i] ? m_lat[i] : (pins[i] == m_pol[i]);
            r[i] = p && m_en[i] && !m_msk[i];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_msk = '0; m_kind = '0; m_pol = '0; m_lat = '0; m_prev = '0;
        end else begin
            logic wr;
            logic [NP-1:0] ackv;
            wr = psel && penable && pwrite;
            ackv = (wr && paddr == 12'h04C) ? pwdata[NP-1:0] : '0;
            for (int i = 0; i < NP; i++) begin
                logic ev;
                ev = m_pol[i] ? (pins[i] && !m_prev[i]) : (!pins[i] && m_prev[i]);
                if (m_kind[i] && m_en[i] && ev) m_lat[i] = 1'b1;
                else if (ackv[i])               m_lat[i] = 1'b0;
            end
            m_prev = pins;
            if (wr) begin
                case (paddr)
                    12'h030: m_en   = pwdata[NP-1:0];
                    12'h034: m_msk  = pwdata[NP-1:0];
                    12'h038: m_kind = pwdata[NP-1:0];
                    12'h03C: m_pol  = pwdata[NP-1:0];
                    default: ;
                endcase
            end
        end
        #3;
        if (!done) begin
            chk("R3 per-cycle irq", 32'(irq), 32'(model_irq()));
            chk("R3 per-cycle any", 32'(irq_any), 32'(|model_irq()));
        end
    end

    task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; pwdata = '0;
    endtask

    task automatic rd_reg(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        @(negedge clk); pins = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        rd_reg(12'h030, d); chk("R1 enable", d, 0);
        rd_reg(12'h034, d); chk("R1 mask", d, 0);
        rd_reg(12'h038, d); chk("R1 kind", d, 0);
        rd_reg(12'h03C, d); chk("R1 polarity", d, 0);
        rd_reg(12'h040, d); chk("R1 status", d, 0);
        #1 chk("R1 irq", 32'(irq), 0); chk("R1 any", 32'(irq_any), 0);

        // R2: read-back, upper bits dropped
        wr_reg(12'h030, 32'hFFFF_FFA5); rd_reg(12'h030, d); chk("R2 enable", d, 32'hA5);
        wr_reg(12'h034, 32'h3C);        rd_reg(12'h034, d); chk("R2 mask", d, 32'h3C);
        wr_reg(12'h038, 32'hABCD_000F); rd_reg(12'h038, d); chk("R2 kind", d, 32'h0F);
        wr_reg(12'h03C, 32'hF0);        rd_reg(12'h03C, d); chk("R2 polarity", d, 32'hF0);
        wr_reg(12'h030, 0); wr_reg(12'h034, 0); wr_reg(12'h038, 0);

        // R4: level, active-high then active-low
        wr_reg(12'h03C, 32'hFF); wr_reg(12'h030, 32'hFF);
        #1 chk("R4 idle low", 32'(irq), 0);
        set_pins(8'h81);
        #1 chk("R4 same-cycle high", 32'(irq), 32'h81);
        chk("R3 any high", 32'(irq_any), 1);
        rd_reg(12'h040, d); chk("R3 status level", d, 32'h81);
        wr_reg(12'h03C, 32'h00);
        #1 chk("R4 active-low", 32'(irq), 32'h7E);
        set_pins(8'h00); wr_reg(12'h03C, 32'hFF);
        #1 chk("R4 released", 32'(irq), 0);

        // R5 / R6: rising edge latch and acknowledge
        wr_reg(12'h038, 32'hFF);
        set_pins(8'h01);
        #1 chk("R5 not before clock", 32'(irq), 0);
        @(negedge clk); #1 chk("R5 rising latched", 32'(irq), 32'h01);
        set_pins(8'h00); wait_cyc(1);
        #1 chk("R6 held after pin drop", 32'(irq), 32'h01);
        wr_reg(12'h04C, 32'h02);
        #1 chk("R6 zero bits no clear", 32'(irq), 32'h01);
        wr_reg(12'h04C, 32'h01);
        #1 chk("R6 cleared", 32'(irq), 0);

        // R5: falling edge on pin 1
        wr_reg(12'h03C, 32'hFD);
        set_pins(8'h02); wait_cyc(1);
        #1 chk("R5 rise ignored on falling pin", 32'(irq), 0);
        set_pins(8'h00); wait_cyc(1);
        #1 chk("R5 falling latched", 32'(irq), 32'h02);
        wr_reg(12'h04C, 32'h02); wr_reg(12'h03C, 32'hFF);
        #1 chk("R6 falling cleared", 32'(irq), 0);

        // R7: edge while disabled is lost
        wr_reg(12'h030, 32'hFB);
        set_pins(8'h04); wait_cyc(1); set_pins(8'h00);
        wr_reg(12'h030, 32'hFF);
        wait_cyc(1);
        #1 chk("R7 disabled edge lost", 32'(irq), 0);

        // R8: mask hides, keeps latch
        wr_reg(12'h034, 32'h01);
        set_pins(8'h01); wait_cyc(1);
        #1 chk("R8 masked irq", 32'(irq), 0);
        rd_reg(12'h040, d); chk("R8 masked status", d, 0);
        wr_reg(12'h034, 32'h00);
        #1 chk("R8 unmask restores", 32'(irq), 32'h01);
        rd_reg(12'h040, d); chk("R3 status edge", d, 32'h01);
        wr_reg(12'h04C, 32'h01); set_pins(8'h00);

        // R9: acknowledge does nothing to an active level pin
        wr_reg(12'h038, 32'hF7);
        set_pins(8'h08);
        #1 chk("R9 level active", 32'(irq), 32'h08);
        wr_reg(12'h04C, 32'h08);
        #1 chk("R9 ack ignored", 32'(irq), 32'h08);
        set_pins(8'h00); wr_reg(12'h038, 32'hFF);
        #1 chk("R9 level gone", 32'(irq), 0);

        // R10: acknowledge and new edge on the same clock
        set_pins(8'h10); set_pins(8'h00);
        #1 chk("R10 pre latched", 32'(irq), 32'h10);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 12'h04C; pwdata = 32'h10;
        @(negedge clk); penable = 1; pins = 8'h10;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; pwdata = '0;
        #1 chk("R10 edge wins", 32'(irq), 32'h10);
        wr_reg(12'h04C, 32'h10);
        #1 chk("R10 later ack clears", 32'(irq), 0);
        set_pins(8'h00);

        // R11: clear offset reads zero, status write inert
        rd_reg(12'h04C, d); chk("R11 clear reads zero", d, 0);
        set_pins(8'h20); wait_cyc(1);
        wr_reg(12'h040, 32'h00);
        #1 chk("R11 status write inert", 32'(irq), 32'h20);
        rd_reg(12'h040, d); chk("R11 status kept", d, 32'h20);
        rd_reg(12'h030, d); chk("R11 enable kept", d, 32'hFF);
        wr_reg(12'h04C, 32'hFF); set_pins(8'h00);
        wait_cyc(2);
        #1 chk("R3 final quiet any", 32'(irq_any), 0);

        finish_run();
    end

endmodule